// File: doc/BRIEF.md
# BCH Bit-Flip Correction Applier

This block sits after a BCH error locator. It applies the bit corrections for one 512-byte sector that is protected by either an 8-bit-strength code (14 ECC bytes, the last one a reserved pad) or a 16-bit-strength code (26 ECC bytes). A pulse on `start_i` latches the strength mode and the number of error locations to expect. The block then checks the ECC buffers, takes in locations, and writes the corrected bytes back into the sector data buffer or the stored ECC buffer through byte-wide memory ports. Each memory port returns read data one cycle after a read strobe.

The checks come first. The block reads the computed-syndrome ECC bytes and the stored ECC bytes, one index per cycle. A sector whose computed bytes are all zero is clean. A sector whose stored bytes are all 0xFF is erased. In both cases the block finishes without taking any location. Otherwise it consumes locations from a valid/ready stream. The producer holds `loc_valid_i` and `loc_i` until it sees `loc_ready_o`, and `loc_ready_o` stays low while a read-modify-write is in flight. Each location counts bits backward from the end of the combined data-plus-ECC codeword. Positions that fall outside that codeword raise an error flag and are not applied. A one-cycle `done_o` pulse reports the status code and the count of flips applied.

Top module: `bch_fix_apply`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `loc_ready_o` and every memory strobe are low.
- R2: After `start_i`, the block reads ECC index 0 up to N-1 on both the syndrome port and the stored-ECC port, with N=14 when `mode16_i`=0 and N=26 when `mode16_i`=1. No location is accepted before all N syndrome reads have been issued.
- R3: If all N syndrome bytes are zero, the run ends with status 1 (clean) and a fix count of 0. No location is accepted and no buffer is written. This test takes priority over R4.
- R4: Otherwise, if all N stored ECC bytes are 0xFF (in 8-bit mode this includes the reserved byte 13), the run ends with status 2 (erased). No location is accepted and no write occurs.
- R5: A location L maps to codeword byte P = LIM-1-floor(L/8) and bit L mod 8. LIM is 525 in 8-bit mode and 538 in 16-bit mode.
- R6: When P < 512, data byte P is read, and two cycles after the read strobe it is written back with the read value XOR (1 << bit). The address is unchanged between the read and the write.
- R7: When 512 <= P < LIM, stored ECC byte P-512 is flipped in the same way. In 8-bit mode, ECC byte 13 is never written.
- R8: When floor(L/8) >= LIM, nothing is written for that location. The run still consumes the remaining locations and ends with status 3 (bad location). The fix count is the number of flips actually applied.
- R9: When every location is in range, the run ends with status 0 and the fix count equals the location count. A location count of 0 ends at once with count 0.
- R10: A location count above 16 is clamped to 16. Exactly 16 locations are taken.
- R11: A location is taken only on a cycle where `loc_valid_i` and `loc_ready_o` are both high. Gaps in valid are tolerated, and exactly the expected number of locations are taken per run.
- R12: `start_i`, `mode16_i` and `nerr_i` are ignored while `busy_o` is high.
- R13: `done_o` is a one-cycle pulse. `status_o` and `nfixed_o` hold their values until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (sampled only when idle) |
| mode16_i | input | 1 | 0: 8-bit strength, 1: 16-bit strength |
| nerr_i | input | 5 | Number of locations to expect |
| loc_valid_i | input | 1 | Location stream valid |
| loc_ready_o | output | 1 | Location stream ready |
| loc_i | input | 13 | Bit location counted from codeword end |
| dat_rd_o | output | 1 | Data buffer read strobe |
| dat_wr_o | output | 1 | Data buffer write strobe |
| dat_addr_o | output | 9 | Data buffer byte address |
| dat_wdata_o | output | 8 | Data buffer write byte |
| dat_rdata_i | input | 8 | Data buffer read byte (one cycle after read) |
| ecc_rd_o | output | 1 | Stored-ECC buffer read strobe |
| ecc_wr_o | output | 1 | Stored-ECC buffer write strobe |
| ecc_addr_o | output | 5 | Stored-ECC byte address |
| ecc_wdata_o | output | 8 | Stored-ECC write byte |
| ecc_rdata_i | input | 8 | Stored-ECC read byte |
| syn_rd_o | output | 1 | Computed-ECC read strobe |
| syn_addr_o | output | 5 | Computed-ECC byte address |
| syn_rdata_i | input | 8 | Computed-ECC read byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 fixed, 1 clean, 2 erased, 3 bad location |
| nfixed_o | output | 5 | Flips applied in the last run |

## Verification
The bench targets the codeword ends in both modes. Location 0 must land on the last real ECC byte, and in 8-bit mode that is byte 12, not the reserved byte 13. The largest legal location must land on data byte 0. A design that forgot the pad byte, or that counted forward, would write the wrong byte. The bench also sends locations one byte past the limit and the largest encodable location. A design that wrapped the subtraction would corrupt a buffer instead of flagging status 3. Two flips to the same byte in back-to-back locations expose a read-modify-write that reads stale data. A clean syndrome combined with an erased stored ECC checks the priority between R3 and R4. A stored ECC that is all 0xFF except the reserved byte shows whether the erased test wrongly skips that byte. Finally, location streams are held valid past the expected count, and the bench pulses start during a run. A design that over-consumes locations, or that restarts mid-run, produces extra writes, which the per-clock write comparison catches.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

  typedef enum logic [1:0] {
    ST_FIXED  = 2'd0,
    ST_CLEAN  = 2'd1,
    ST_ERASED = 2'd2,
    ST_BADLOC = 2'd3
  } fix_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_SCAN_WAIT,
    S_ACCEPT,
    S_RD,
    S_WR
  } fix_state_e;

endpackage

// File: rtl/bchfix_precheck.sv
module bchfix_precheck #(
  parameter int unsigned MAX_SMP = 26,
  localparam int unsigned CNT_W = $clog2(MAX_SMP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             smp_i,
  input  logic [7:0]       syn_i,
  input  logic [7:0]       sto_i,
  output logic             zero_o,
  output logic             erased_o,
  output logic [CNT_W-1:0] nsmp_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_o   <= 1'b1;
      erased_o <= 1'b1;
      nsmp_o   <= '0;
    end else if (clear_i) begin
      zero_o   <= 1'b1;
      erased_o <= 1'b1;
      nsmp_o   <= '0;
    end else if (smp_i) begin
      zero_o   <= zero_o & (syn_i == 8'h00);
      erased_o <= erased_o & (sto_i == 8'hFF);
      nsmp_o   <= nsmp_o + 1'b1;
    end
  end

  AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i |-> (nsmp_o < CNT_W'(MAX_SMP))); // R2

endmodule

// File: rtl/bchfix_locmap.sv
module bchfix_locmap #(
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned LIM8       = 525,
  parameter int unsigned LIM16      = 538,
  parameter int unsigned LOC_W      = 13,
  parameter int unsigned DAT_AW     = 9,
  parameter int unsigned ECC_AW     = 5,
  localparam int unsigned POS_W     = LOC_W - 3
) (
  input  logic              mode16_i,
  input  logic [LOC_W-1:0]  loc_i,
  output logic              bad_o,
  output logic              to_dat_o,
  output logic [DAT_AW-1:0] dat_addr_o,
  output logic [ECC_AW-1:0] ecc_addr_o,
  output logic [7:0]        mask_o
);

  logic [POS_W-1:0] byte_idx, lim, pos, eoff;

  always_comb begin
    byte_idx   = loc_i[LOC_W-1:3];
    lim        = mode16_i ? POS_W'(LIM16) : POS_W'(LIM8);
    bad_o      = (byte_idx >= lim);
    pos        = lim - byte_idx - POS_W'(1);
    to_dat_o   = (pos < POS_W'(SECT_BYTES));
    eoff       = pos - POS_W'(SECT_BYTES);
    dat_addr_o = pos[DAT_AW-1:0];
    ecc_addr_o = eoff[ECC_AW-1:0];
    mask_o     = 8'd1 << loc_i[2:0];
  end

  always_comb begin
    if (!bad_o && !to_dat_o) begin
      AST_ECC_OFFSET_OK: assert (int'(eoff) < (mode16_i ? int'(LIM16 - SECT_BYTES)
                                                      : int'(LIM8 - SECT_BYTES))); // R7
    end
  end

endmodule

// File: rtl/bch_fix_apply.sv
module bch_fix_apply
  import bchfix_pkg::*;
#(
  parameter int unsigned SECT_BYTES  = 512,
  parameter int unsigned ECC8_BYTES  = 14,
  parameter int unsigned ECC16_BYTES = 26,
  parameter int unsigned MAX_LOCS    = 16,
  localparam int unsigned DAT_AW = $clog2(SECT_BYTES),
  localparam int unsigned ECC_AW = $clog2(ECC16_BYTES),
  localparam int unsigned LIM8   = SECT_BYTES + ECC8_BYTES - 1,
  localparam int unsigned LIM16  = SECT_BYTES + ECC16_BYTES,
  localparam int unsigned LOC_W  = $clog2(LIM16 * 8),
  localparam int unsigned CNT_W  = $clog2(MAX_LOCS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode16_i,
  input  logic [CNT_W-1:0]  nerr_i,
  input  logic              loc_valid_i,
  output logic              loc_ready_o,
  input  logic [LOC_W-1:0]  loc_i,
  output logic              dat_rd_o,
  output logic              dat_wr_o,
  output logic [DAT_AW-1:0] dat_addr_o,
  output logic [7:0]        dat_wdata_o,
  input  logic [7:0]        dat_rdata_i,
  output logic              ecc_rd_o,
  output logic              ecc_wr_o,
  output logic [ECC_AW-1:0] ecc_addr_o,
  output logic [7:0]        ecc_wdata_o,
  input  logic [7:0]        ecc_rdata_i,
  output logic              syn_rd_o,
  output logic [ECC_AW-1:0] syn_addr_o,
  input  logic [7:0]        syn_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [CNT_W-1:0]  nfixed_o
);

  localparam int unsigned SCNT_W = $clog2(ECC16_BYTES + 1);

  fix_state_e        state_q;
  fix_status_e       status_q;
  logic              mode_q;
  logic [CNT_W-1:0]  rem_q, fixed_q;
  logic              bad_q;
  logic [ECC_AW-1:0] idx_q;
  logic              scan_d1_q;
  logic              tgt_dat_q;
  logic [7:0]        mask_q;
  logic [SCNT_W-1:0] nbytes;
  logic [CNT_W-1:0]  nerr_clamped;
  logic              take;

  logic              scan_zero, scan_ff;
  logic [SCNT_W-1:0] scan_cnt;
  logic              map_bad, map_to_dat;
  logic [DAT_AW-1:0] map_dat_addr;
  logic [ECC_AW-1:0] map_ecc_addr;
  logic [7:0]        map_mask;

  assign nbytes       = mode_q ? SCNT_W'(ECC16_BYTES) : SCNT_W'(ECC8_BYTES);
  assign nerr_clamped = (nerr_i > CNT_W'(MAX_LOCS)) ? CNT_W'(MAX_LOCS) : nerr_i;
  assign loc_ready_o  = (state_q == S_ACCEPT) && (rem_q != '0);
  assign take         = loc_ready_o && loc_valid_i;
  assign busy_o       = (state_q != S_IDLE);
  assign status_o     = status_q;

  bchfix_precheck #(.MAX_SMP(ECC16_BYTES)) u_precheck (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  ((state_q == S_IDLE) && start_i),
    .smp_i    (scan_d1_q),
    .syn_i    (syn_rdata_i),
    .sto_i    (ecc_rdata_i),
    .zero_o   (scan_zero),
    .erased_o (scan_ff),
    .nsmp_o   (scan_cnt)
  );

  bchfix_locmap #(
    .SECT_BYTES (SECT_BYTES),
    .LIM8       (LIM8),
    .LIM16      (LIM16),
    .LOC_W      (LOC_W),
    .DAT_AW     (DAT_AW),
    .ECC_AW     (ECC_AW)
  ) u_locmap (
    .mode16_i   (mode_q),
    .loc_i      (loc_i),
    .bad_o      (map_bad),
    .to_dat_o   (map_to_dat),
    .dat_addr_o (map_dat_addr),
    .ecc_addr_o (map_ecc_addr),
    .mask_o     (map_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      status_q    <= ST_FIXED;
      mode_q      <= 1'b0;
      rem_q       <= '0;
      fixed_q     <= '0;
      bad_q       <= 1'b0;
      idx_q       <= '0;
      scan_d1_q   <= 1'b0;
      tgt_dat_q   <= 1'b0;
      mask_q      <= '0;
      dat_rd_o    <= 1'b0;
      dat_wr_o    <= 1'b0;
      dat_addr_o  <= '0;
      dat_wdata_o <= '0;
      ecc_rd_o    <= 1'b0;
      ecc_wr_o    <= 1'b0;
      ecc_addr_o  <= '0;
      ecc_wdata_o <= '0;
      syn_rd_o    <= 1'b0;
      syn_addr_o  <= '0;
      done_o      <= 1'b0;
      nfixed_o    <= '0;
    end else begin
      dat_rd_o  <= 1'b0;
      dat_wr_o  <= 1'b0;
      ecc_rd_o  <= 1'b0;
      ecc_wr_o  <= 1'b0;
      syn_rd_o  <= 1'b0;
      done_o    <= 1'b0;
      scan_d1_q <= syn_rd_o;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            mode_q  <= mode16_i;
            rem_q   <= nerr_clamped;
            fixed_q <= '0;
            bad_q   <= 1'b0;
            idx_q   <= '0;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          ecc_rd_o   <= 1'b1;
          syn_rd_o   <= 1'b1;
          ecc_addr_o <= idx_q;
          syn_addr_o <= idx_q;
          idx_q      <= idx_q + 1'b1;
          if (SCNT_W'(idx_q) == nbytes - 1'b1) state_q <= S_SCAN_WAIT;
        end
        S_SCAN_WAIT: begin
          if (scan_cnt == nbytes) begin
            if (scan_zero) begin
              status_q <= ST_CLEAN;
              nfixed_o <= '0;
              done_o   <= 1'b1;
              state_q  <= S_IDLE;
            end else if (scan_ff) begin
              status_q <= ST_ERASED;
              nfixed_o <= '0;
              done_o   <= 1'b1;
              state_q  <= S_IDLE;
            end else begin
              state_q  <= S_ACCEPT;
            end
          end
        end
        S_ACCEPT: begin
          if (rem_q == '0) begin
            status_q <= bad_q ? ST_BADLOC : ST_FIXED;
            nfixed_o <= fixed_q;
            done_o   <= 1'b1;
            state_q  <= S_IDLE;
          end else if (take) begin
            rem_q <= rem_q - 1'b1;
            if (map_bad) begin
              bad_q <= 1'b1;
            end else begin
              tgt_dat_q <= map_to_dat;
              mask_q    <= map_mask;
              if (map_to_dat) begin
                dat_rd_o   <= 1'b1;
                dat_addr_o <= map_dat_addr;
              end else begin
                ecc_rd_o   <= 1'b1;
                ecc_addr_o <= map_ecc_addr;
              end
              state_q <= S_RD;
            end
          end
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          if (tgt_dat_q) begin
            dat_wr_o    <= 1'b1;
            dat_wdata_o <= dat_rdata_i ^ mask_q;
          end else begin
            ecc_wr_o    <= 1'b1;
            ecc_wdata_o <= ecc_rdata_i ^ mask_q;
          end
          fixed_q <= fixed_q + 1'b1;
          state_q <= S_ACCEPT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_DAT_RMW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_o |-> ($past(dat_rd_o, 2) && $stable(dat_addr_o))); // R6
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dat_wr_o, ecc_wr_o})); // R6
  AST_PAD_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_wr_o && !mode_q) |-> (ecc_addr_o < ECC_AW'(ECC8_BYTES - 1))); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    loc_ready_o |-> busy_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R13
  AST_CLEAN_NOFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (status_o == ST_CLEAN)) |-> (nfixed_o == '0)); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (nfixed_o <= CNT_W'(MAX_LOCS))); // R10
  AST_NO_TAKE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    syn_rd_o |-> !loc_ready_o); // R2

endmodule

// File: tb/bch_fix_apply_tb_top.sv
module bch_fix_apply_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode16_i, loc_valid_i;
  logic [4:0]  nerr_i;
  logic [12:0] loc_i;
  logic        loc_ready_o;
  logic        dat_rd_o, dat_wr_o, ecc_rd_o, ecc_wr_o, syn_rd_o;
  logic [8:0]  dat_addr_o;
  logic [4:0]  ecc_addr_o, syn_addr_o;
  logic [7:0]  dat_wdata_o, ecc_wdata_o;
  logic [7:0]  dat_rdata_i, ecc_rdata_i, syn_rdata_i;
  logic        busy_o, done_o;
  logic [1:0]  status_o;
  logic [4:0]  nfixed_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_fix_apply dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode16_i(mode16_i), .nerr_i(nerr_i),
    .loc_valid_i(loc_valid_i), .loc_ready_o(loc_ready_o), .loc_i(loc_i),
    .dat_rd_o(dat_rd_o), .dat_wr_o(dat_wr_o), .dat_addr_o(dat_addr_o),
    .dat_wdata_o(dat_wdata_o), .dat_rdata_i(dat_rdata_i),
    .ecc_rd_o(ecc_rd_o), .ecc_wr_o(ecc_wr_o), .ecc_addr_o(ecc_addr_o),
    .ecc_wdata_o(ecc_wdata_o), .ecc_rdata_i(ecc_rdata_i),
    .syn_rd_o(syn_rd_o), .syn_addr_o(syn_addr_o), .syn_rdata_i(syn_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .nfixed_o(nfixed_o)
  );

  logic [7:0] dmem [0:511];
  logic [7:0] emem [0:25];
  logic [7:0] smem [0:25];
  logic [7:0] mdat [0:511];
  logic [7:0] mecc [0:25];

  always @(posedge clk) begin
    if (dat_wr_o) dmem[dat_addr_o] <= dat_wdata_o;
    if (dat_rd_o) dat_rdata_i <= dmem[dat_addr_o];
    if (ecc_wr_o) emem[ecc_addr_o] <= ecc_wdata_o;
    if (ecc_rd_o) ecc_rdata_i <= emem[ecc_addr_o];
    if (syn_rd_o) syn_rdata_i <= smem[syn_addr_o];
  end

  int nchk = 0;
  int nerr_cnt = 0;
  int qt[$];
  int qa[$];
  int qv[$];
  int hs_cnt, syn_seen, exp_scan;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock comparison of every buffer write against the reference queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (syn_rd_o) syn_seen++;
      if (loc_valid_i && loc_ready_o) begin
        if (hs_cnt == 0) chk("R2 scan reads before first location", syn_seen, exp_scan);
        hs_cnt++;
      end
      if (dat_wr_o || ecc_wr_o) begin
        if (qt.size() == 0) begin
          chk("R11 unexpected buffer write", 1, 0);
        end else begin
          int t, a, v;
          t = qt.pop_front(); a = qa.pop_front(); v = qv.pop_front();
          chk("R6/R7 write target", int'(ecc_wr_o), t);
          if (t == 0) chk("R6 data write addr*256+value", int'(dat_addr_o)*256 + int'(dat_wdata_o), a*256 + v);
          else        chk("R7 ecc write addr*256+value", int'(ecc_addr_o)*256 + int'(ecc_wdata_o), a*256 + v);
        end
      end
    end
  end

  task automatic fill(input int seed, input bit syn_zero, input bit ecc_ff, input bit pad_zero);
    for (int i = 0; i < 512; i++) begin
      dmem[i] = 8'(i*13 + seed); mdat[i] = 8'(i*13 + seed);
    end
    for (int i = 0; i < 26; i++) begin
      emem[i] = ecc_ff ? 8'hFF : 8'(i*5 + seed + 1);
      if (pad_zero && i == 13) emem[i] = 8'h00;
      mecc[i] = emem[i];
      smem[i] = syn_zero ? 8'h00 : 8'(i*3 + seed + 1);
    end
  endtask

  task automatic run_case(input string name, input bit mode, input int nerr, input int locs[$],
                          input int gap, input bit poke);
    int n, lim, k, fixed, est, efix, q, pos, mism;
    bit clean, er, bad;
    logic [7:0] m;
    n = mode ? 26 : 14;
    lim = mode ? 538 : 525;
    clean = 1; er = 1; bad = 0; fixed = 0;
    for (int i = 0; i < n; i++) begin
      if (smem[i] != 8'h00) clean = 0;
      if (emem[i] != 8'hFF) er = 0;
    end
    k = (nerr > 16) ? 16 : nerr;
    if (!clean && !er) begin
      for (int i = 0; i < k; i++) begin
        q = locs[i] / 8;
        m = 8'd1 << (locs[i] % 8);
        if (q >= lim) bad = 1;
        else begin
          pos = lim - 1 - q;
          if (pos < 512) begin
            mdat[pos] ^= m; qt.push_back(0); qa.push_back(pos); qv.push_back(int'(mdat[pos]));
          end else begin
            mecc[pos-512] ^= m; qt.push_back(1); qa.push_back(pos-512); qv.push_back(int'(mecc[pos-512]));
          end
          fixed++;
        end
      end
    end
    est  = clean ? 1 : (er ? 2 : (bad ? 3 : 0));
    efix = (clean || er) ? 0 : fixed;
    if (clean || er) k = 0;
    hs_cnt = 0; syn_seen = 0; exp_scan = n;
    @(negedge clk);
    start_i = 1; mode16_i = mode; nerr_i = 5'(nerr);
    @(negedge clk);
    start_i = 0;
    for (int i = 0; i < k; i++) begin
      repeat (gap) @(negedge clk);
      loc_valid_i = 1; loc_i = 13'(locs[i]);
      while (!loc_ready_o) @(negedge clk);
      @(negedge clk);
      loc_valid_i = 0;
      if (poke && i == 0) begin
        start_i = 1; mode16_i = ~mode; nerr_i = 5'd0;
        @(negedge clk);
        start_i = 0;
      end
    end
    loc_valid_i = 1; loc_i = 13'd4199;
    for (int t = 0; t < 3000 && !done_o; t++) @(negedge clk);
    loc_valid_i = 0;
    chk({name, " R13 done seen"}, int'(done_o), 1);
    chk({name, " R3/R4/R8/R9 status"}, int'(status_o), est);
    chk({name, " R8/R9 fix count"}, int'(nfixed_o), efix);
    chk({name, " R10/R11 locations taken"}, hs_cnt, k);
    chk({name, " R11 pending writes"}, qt.size(), 0);
    mism = 0;
    for (int i = 0; i < 512; i++) if (dmem[i] !== mdat[i]) mism++;
    for (int i = 0; i < 26; i++) if (emem[i] !== mecc[i]) mism++;
    chk({name, " R6/R7 buffer contents"}, mism, 0);
    @(negedge clk);
    chk({name, " R13 done is one cycle"}, int'(done_o), 0);
    chk({name, " R13 status held"}, int'(status_o), est);
    chk({name, " R1 idle after run"}, int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr_cnt);
    $finish;
  end

  initial begin
    int l[$];
    rst_n = 0; start_i = 0; mode16_i = 0; nerr_i = 0; loc_valid_i = 0; loc_i = 0;
    hs_cnt = 0; syn_seen = 0; exp_scan = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 ready", int'(loc_ready_o), 0);
    chk("R1 strobes", int'({dat_rd_o, dat_wr_o, ecc_rd_o, ecc_wr_o, syn_rd_o}), 0);

    // R3 clean sector, locations held valid must be ignored
    fill(1, 1, 0, 0); l = '{100, 200};
    run_case("clean", 0, 2, l, 0, 0);
    // R3 priority over R4
    fill(2, 1, 1, 0);
    run_case("clean+erased", 1, 2, l, 0, 0);
    // R4 erased
    fill(3, 0, 1, 0);
    run_case("erased16", 1, 3, l, 0, 0);
    fill(4, 0, 1, 0);
    run_case("erased8", 0, 3, l, 0, 0);
    // R4 pad byte is scanned: not erased
    fill(5, 0, 1, 1); l = '{4199};
    run_case("pad-not-erased", 0, 1, l, 0, 0);
    // R5 R6 R7 8-bit mapping at both ends
    fill(6, 0, 0, 0); l = '{0, 109, 4199, 99};
    run_case("map8", 0, 4, l, 2, 0);
    // R5 R6 R7 16-bit mapping
    fill(7, 0, 0, 0); l = '{7, 4298, 208, 100};
    run_case("map16", 1, 4, l, 0, 0);
    // R8 bad locations in 8-bit mode
    fill(8, 0, 0, 0); l = '{4200, 4199, 8191};
    run_case("bad8", 0, 3, l, 1, 0);
    // R8 bad location in 16-bit mode
    fill(9, 0, 0, 0); l = '{4304, 4303};
    run_case("bad16", 1, 2, l, 0, 0);
    // R9 zero count
    fill(10, 0, 0, 0); l = '{};
    run_case("zero-count", 1, 0, l, 0, 0);
    // R10 clamp, plus back-to-back flips of one byte
    fill(11, 0, 0, 0);
    l = '{4199, 4198, 0, 1, 50, 51, 300, 301, 1000, 2000, 3000, 4000, 4100, 4150, 17, 18, 19, 20};
    run_case("clamp16", 0, 31, l, 0, 0);
    // R12 start ignored while busy
    fill(12, 0, 0, 0); l = '{10, 20, 30};
    run_case("restart-ignored", 1, 3, l, 0, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr_cnt);
    $finish;
  end

endmodule